// File: doc/BRIEF.md
# Three-Tier Bus Ownership Arbiter

This block decides which of four masters drives a shared bus. An external bus request has the highest priority. Two DMA channels come next, and the CPU has the lowest priority. The order between the two DMA channels comes from a programmed level for each channel. When nobody asks for the bus, ownership parks on the CPU.

Ownership only moves at operand boundaries. Each master reports every bus cycle it completes with a strobe, together with two tags:
- **Last:** the cycle ends the current operand.
- **RMW:** the operand continues as the write half of an indivisible read-modify-write.

While an operand is in progress the bus is locked to its owner. A higher-priority request cannot take the bus until the owner completes a cycle tagged last and not RMW. This gives the following behaviour:
- A long-word write to a byte-wide port keeps the bus for all four cycles.
- A dual-address DMA transfer has separate read and write operands, so it can lose the bus between them.
- A block register move can lose the bus between its operands.

The interface carries no data stream. All pins are plain level or strobe signals, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_owner_arb`

## Requirements
- R1: After reset `grant` is 4'b1000 (CPU) and `bus_busy` is 0.
- R2: `grant` is always one-hot. Bit 0 is the external requester, bit 1 is DMA channel 0, bit 2 is DMA channel 1 and bit 3 is the CPU. The same bit mapping applies to `m_req`, `m_done`, `m_last` and `m_rmw`.
- R3: When arbitration is open, a request on bit 0 wins over every other request.
- R4: When arbitration is open and there is no external request, either DMA request wins over a CPU request.
- R5: When both DMA channels request, the channel with the numerically larger level wins.
- R6: When the two levels are equal, `level_clash` is 1 and DMA channel 0 wins. When the levels differ, `level_clash` is 0.
- R7: When arbitration is open and no master requests, `grant` becomes 4'b1000.
- R8: After the owner completes a cycle that does not end its operand, `grant` stays unchanged, whatever requests arrive, until the operand ends.
- R9: An operand ends at a clock edge where the owner has `m_done`=1, `m_last`=1 and `m_rmw`=0. The new grant is visible from that edge on, so it appears one clock after the last cycle completes.
- R10: A cycle tagged `m_last`=1 with `m_rmw`=1 does not end the operand. The bus stays locked through the write half.
- R11: Arbitration is open when no operand is in progress. While open, `grant` follows the current winner and updates at every clock edge.
- R12: `bus_busy` is 1 from the edge where the owner completes a non-ending cycle until the edge where its operand ends.
- R13: `m_done`, `m_last` and `m_rmw` from a master that does not hold the grant are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 4 | Request per master (bit 0 external, 1 DMA0, 2 DMA1, 3 CPU) |
| m_done | input | 4 | Strobe: the master completed a bus cycle this clock |
| m_last | input | 4 | Tag: the completed cycle ends its operand |
| m_rmw | input | 4 | Tag: the operand continues as an indivisible write half |
| dma0_level | input | LVL_W | Programmed priority level of DMA channel 0 |
| dma1_level | input | LVL_W | Programmed priority level of DMA channel 1 |
| grant | output | 4 | One-hot bus owner |
| bus_busy | output | 1 | An operand is in progress; grant is locked |
| level_clash | output | 1 | The two DMA levels are equal (configuration error) |

## Verification
The hardest situation to reach is a preemption attempt that lands in the middle of a locked sequence. A higher-priority request has to appear while the owner is between the cycles of one operand. This includes the gap between the read and write halves of a read-modify-write, and the moment a non-owner pulses its own last-cycle strobe.

The directed tasks reach this state in three steps:
1. Grant the bus to a low-priority master while the bus is idle.
2. Issue one non-final cycle strobe so the lock closes.
3. Raise the external request. Step through the remaining cycles one clock at a time, checking at each step that the grant holds.

The final strobe is then checked by expecting the handover exactly one clock later.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_M = 4;
  localparam int IDX_EXT  = 0;
  localparam int IDX_DMA0 = 1;
  localparam int IDX_DMA1 = 2;
  localparam int IDX_CPU  = 3;

  typedef logic [NUM_M-1:0] mvec_t;

  localparam mvec_t PARK_GRANT = mvec_t'(1) << IDX_CPU;
endpackage

// File: rtl/dma_rank.sv
module dma_rank #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl_a,
  input  logic [LVL_W-1:0] lvl_b,
  output logic             a_first,
  output logic             clash
);
  // Larger level ranks first; equal levels fall back to channel A.
  always_comb begin
    clash   = (lvl_a == lvl_b);
    a_first = (lvl_a >= lvl_b);
  end
endmodule

// File: rtl/class_pick.sv
module class_pick
  import arb_pkg::*;
(
  input  mvec_t req,
  input  logic  dma0_first,
  output mvec_t win
);
  int unsigned order [NUM_M];

  always_comb begin
    order[0] = IDX_EXT;
    order[1] = dma0_first ? IDX_DMA0 : IDX_DMA1;
    order[2] = dma0_first ? IDX_DMA1 : IDX_DMA0;
    order[3] = IDX_CPU;
  end

  always_comb begin
    logic found;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < NUM_M; k++) begin
      if (!found && req[order[k]]) begin
        win[order[k]] = 1'b1;
        found         = 1'b1;
      end
    end
    if (!found) win = PARK_GRANT;
  end
endmodule

// File: rtl/cycle_tag_reduce.sv
module cycle_tag_reduce
  import arb_pkg::*;
(
  input  mvec_t owner,
  input  mvec_t done,
  input  mvec_t last,
  input  mvec_t rmw,
  output logic  own_done,
  output logic  own_end
);
  mvec_t done_v;
  mvec_t end_v;

  for (genvar i = 0; i < NUM_M; i++) begin : g_tag
    assign done_v[i] = owner[i] & done[i];
    assign end_v[i]  = owner[i] & done[i] & last[i] & ~rmw[i];
  end

  assign own_done = |done_v;
  assign own_end  = |end_v;
endmodule

// File: rtl/owner_lock.sv
module owner_lock
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mvec_t win,
  input  logic  own_done,
  input  logic  own_end,
  output mvec_t owner,
  output logic  locked
);
  mvec_t owner_q;
  logic  locked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= PARK_GRANT;
      locked_q <= 1'b0;
    end else if (own_done && own_end) begin
      owner_q  <= win;
      locked_q <= 1'b0;
    end else if (own_done) begin
      locked_q <= 1'b1;
    end else if (!locked_q) begin
      owner_q <= win;
    end
  end

  assign owner  = owner_q;
  assign locked = locked_q;
endmodule

// File: rtl/bus_owner_arb.sv
module bus_owner_arb
  import arb_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       m_req,
  input  logic [3:0]       m_done,
  input  logic [3:0]       m_last,
  input  logic [3:0]       m_rmw,
  input  logic [LVL_W-1:0] dma0_level,
  input  logic [LVL_W-1:0] dma1_level,
  output logic [3:0]       grant,
  output logic             bus_busy,
  output logic             level_clash
);
  logic  dma0_first;
  mvec_t win;
  mvec_t owner;
  logic  own_done;
  logic  own_end;

  dma_rank #(.LVL_W(LVL_W)) u_rank (
    .lvl_a   (dma0_level),
    .lvl_b   (dma1_level),
    .a_first (dma0_first),
    .clash   (level_clash)
  );

  class_pick u_pick (
    .req        (m_req),
    .dma0_first (dma0_first),
    .win        (win)
  );

  cycle_tag_reduce u_tags (
    .owner    (owner),
    .done     (m_done),
    .last     (m_last),
    .rmw      (m_rmw),
    .own_done (own_done),
    .own_end  (own_end)
  );

  owner_lock u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .win      (win),
    .own_done (own_done),
    .own_end  (own_end),
    .owner    (owner),
    .locked   (bus_busy)
  );

  assign grant = owner;
endmodule

// File: rtl/bus_owner_arb_chk.sv
module bus_owner_arb_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       m_req,
  input logic [3:0]       m_done,
  input logic [3:0]       m_last,
  input logic [3:0]       m_rmw,
  input logic [LVL_W-1:0] dma0_level,
  input logic [LVL_W-1:0] dma1_level,
  input logic [3:0]       grant,
  input logic             bus_busy,
  input logic             level_clash
);
  logic any_own_done;
  logic own_finish;
  logic arb_open;

  assign any_own_done = |(grant & m_done);
  assign own_finish   = |(grant & m_done & m_last & ~m_rmw);
  assign arb_open     = (!bus_busy && !any_own_done) || own_finish;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(grant) == 1);

  // R3
  ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_open && m_req[0] |=> grant == 4'b0001);

  // R7
  park_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_open && m_req == 4'b0000 |=> grant == 4'b1000);

  // R8
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_open |=> $stable(grant));

  // R12
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_own_done && !own_finish |=> bus_busy);

  // R6
  tie_dma0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arb_open && m_req == 4'b0110 && dma0_level == dma1_level |=> grant == 4'b0010);
endmodule

bind bus_owner_arb bus_owner_arb_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .m_req       (m_req),
  .m_done      (m_done),
  .m_last      (m_last),
  .m_rmw       (m_rmw),
  .dma0_level  (dma0_level),
  .dma1_level  (dma1_level),
  .grant       (grant),
  .bus_busy    (bus_busy),
  .level_clash (level_clash)
);

// File: tb/bus_owner_arb_test.sv
`timescale 1ns/1ps
module bus_owner_arb_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] m_req = '0, m_done = '0, m_last = '0, m_rmw = '0;
  logic [2:0] dma0_level = 3'd2, dma1_level = 3'd1;
  logic [3:0] grant;
  logic       bus_busy, level_clash;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_owner_arb #(.LVL_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_done(m_done), .m_last(m_last),
    .m_rmw(m_rmw), .dma0_level(dma0_level), .dma1_level(dma1_level),
    .grant(grant), .bus_busy(bus_busy), .level_clash(level_clash)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Completes one cycle for master m; strobe is held across exactly one edge.
  task automatic cyc(input int m, input logic lst, input logic rm);
    m_done[m] = 1'b1; m_last[m] = lst; m_rmw[m] = rm;
    step();
    m_done = '0; m_last = '0; m_rmw = '0;
  endtask

  task automatic go_idle();
    m_req = '0; m_done = '0; m_last = '0; m_rmw = '0;
    dma0_level = 3'd2; dma1_level = 3'd1;
    step();
  endtask

  task automatic t_reset();
    chk("R1 grant after reset", grant, 4'b1000);
    chk("R1 busy after reset", bus_busy, 1'b0);
  endtask

  task automatic t_fixed_priority();
    m_req = 4'b1111; step();
    chk("R3 ext over all", grant, 4'b0001);
    m_req = 4'b1010; step();
    chk("R4 dma0 over cpu", grant, 4'b0010);
    m_req = 4'b1100; step();
    chk("R4 dma1 over cpu", grant, 4'b0100);
    m_req = 4'b1000; step();
    chk("R11 follows winner while open", grant, 4'b1000);
    go_idle();
  endtask

  task automatic t_dma_levels();
    dma0_level = 3'd1; dma1_level = 3'd3; m_req = 4'b0110; step();
    chk("R5 dma1 larger level", grant, 4'b0100);
    chk("R6 no clash when levels differ", level_clash, 1'b0);
    dma0_level = 3'd6; dma1_level = 3'd3; step();
    chk("R5 dma0 larger level", grant, 4'b0010);
    go_idle();
  endtask

  task automatic t_level_clash();
    dma0_level = 3'd4; dma1_level = 3'd4; m_req = 4'b0110; step();
    chk("R6 clash flag", level_clash, 1'b1);
    chk("R6 dma0 wins tie", grant, 4'b0010);
    go_idle();
  endtask

  task automatic t_park();
    m_req = 4'b0001; step();
    chk("R3 ext granted", grant, 4'b0001);
    m_req = 4'b0000; step();
    chk("R7 parks on cpu", grant, 4'b1000);
    go_idle();
  endtask

  // Long word to byte port: four cycles, external request arrives after the first.
  task automatic t_operand_hold();
    m_req = 4'b1000; step();
    cyc(3, 1'b0, 1'b0);
    chk("R12 busy after first cycle", bus_busy, 1'b1);
    m_req = 4'b1001; step();
    chk("R8 hold after ext request", grant, 4'b1000);
    cyc(3, 1'b0, 1'b0);
    chk("R8 hold after cycle 2", grant, 4'b1000);
    cyc(3, 1'b0, 1'b0);
    chk("R8 hold after cycle 3", grant, 4'b1000);
    chk("R12 busy still set", bus_busy, 1'b1);
    m_done[3] = 1'b1; m_last[3] = 1'b1;
    chk("R9 old grant before boundary edge", grant, 4'b1000);
    step(); m_done = '0; m_last = '0;
    chk("R9 handover one clock after last", grant, 4'b0001);
    chk("R12 busy clears at boundary", bus_busy, 1'b0);
    go_idle();
  endtask

  task automatic t_rmw();
    m_req = 4'b1000; step();
    m_req = 4'b1001;
    cyc(3, 1'b1, 1'b1);
    chk("R10 read half keeps grant", grant, 4'b1000);
    chk("R10 read half keeps busy", bus_busy, 1'b1);
    step();
    chk("R10 still locked between halves", grant, 4'b1000);
    cyc(3, 1'b1, 1'b0);
    chk("R10 write half releases", grant, 4'b0001);
    go_idle();
  endtask

  // Dual-address DMA: read and write are separate one-cycle operands.
  task automatic t_dual_address();
    m_req = 4'b0010; step();
    chk("R4 dma0 owns", grant, 4'b0010);
    m_req = 4'b0011;
    cyc(1, 1'b1, 1'b0);
    chk("R9 ext takes bus between read and write", grant, 4'b0001);
    chk("R12 not busy after single-cycle operand", bus_busy, 1'b0);
    go_idle();
  endtask

  task automatic t_foreign_strobes();
    m_req = 4'b1010; step();
    cyc(1, 1'b0, 1'b0);
    chk("R12 dma0 locked", bus_busy, 1'b1);
    m_req = 4'b1011;
    cyc(3, 1'b1, 1'b0);
    chk("R13 cpu strobe ignored grant", grant, 4'b0010);
    chk("R13 cpu strobe ignored busy", bus_busy, 1'b1);
    cyc(0, 1'b1, 1'b0);
    chk("R13 ext strobe ignored", grant, 4'b0010);
    cyc(1, 1'b1, 1'b0);
    chk("R9 owner end hands to ext", grant, 4'b0001);
    go_idle();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_fixed_priority();
    t_dma_levels();
    t_level_clash();
    t_park();
    t_operand_hold();
    t_rmw();
    t_dual_address();
    t_foreign_strobes();
    finished = 1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule